// File: doc/BRIEF.md
# Multi-channel output compare action unit

This block watches a shared 16-bit free-running count and four compare channels, numbered 2 through 5. Each channel holds its own 16-bit compare value. When a new count value arrives, every enabled channel whose compare value equals it reports a match. On a match, the channel either toggles its output latch, drives it low, drives it high, or leaves it alone. The choice comes from a 2-bit action code taken from one shared 8-bit control register.

Channel 5 shares its pin with another function. It takes part only while the pin-sharing select input is low. The count is produced elsewhere and arrives with a strobe, which marks each cycle that carries a new count value. A match can therefore fire only once per count value. Forced compares and interrupt generation belong to other blocks.

Top module: `oc_action_unit`

## Requirements
- R1: After reset, all pin outputs, all output-enable indicators and all match flags are 0. The control register and all compare registers hold 0.
- R2: The control register holds one 2-bit code per channel, packed from MSB to LSB as channel 2 (bits 7:6), channel 3 (bits 5:4), channel 4 (bits 3:2) and channel 5 (bits 1:0). Output vector bit 0 is channel 2 and bit 3 is channel 5. The output-enable bit of a channel is high exactly when its code is non-zero, and for channel 5 only while the select input is also low.
- R3: Code 01 toggles the channel's pin output on a match.
- R4: Code 10 drives the pin output to 0 on a match, and code 11 drives it to 1.
- R5: Under code 00 a match leaves the pin output unchanged, but the channel's match flag still pulses.
- R6: A match occurs in a cycle whose count strobe is high and whose count equals the channel's compare value. The pin update and a one-cycle match flag both appear after that clock edge. A strobe cycle with an unequal count produces no match.
- R7: While the select input is high, channel 5 makes no pin change and raises no match flag, and its output-enable bit is 0.
- R8: A control or compare write takes effect from the next cycle. A match in the same cycle as the write uses the previous register values.
- R9: When the strobe is low, an equal count has no effect on any pin or match flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| count_i | input | 16 | Shared free-running count value |
| count_stb_i | input | 1 | High in the cycle a new count value is presented |
| sel_i | input | 1 | Pin-sharing select; high takes channel 5 out of compare use |
| ctl_we_i | input | 1 | Control register write enable |
| ctl_wdata_i | input | 8 | Control register write data (packed action codes) |
| cmp_we_i | input | 4 | Per-channel compare register write enable (bit 0 = channel 2) |
| cmp_wdata_i | input | 16 | Compare register write data |
| pin_o | output | 4 | Channel output latch levels |
| oe_o | output | 4 | Channel output-enable indicators |
| match_o | output | 4 | One-cycle per-channel match flags |

## Verification
The bench puts one count value on all four channels at once under mixed codes. This shows whether toggle, clear, set and disconnect each act on the right bit pair; swapping the field order would move an action to the wrong channel. It holds an equal count with the strobe low and then presents an unequal strobed count. A design that compared without the strobe, or matched on anything but equality, would raise extra flags or move pins.

With the select input high and channel 5 set to drive high, the bench checks that channel 5 stays untouched and silent. It also writes a compare value in the same cycle that strobes that value. A design that forwarded the new value would match one count too early.

// File: rtl/oc_pkg.sv
package oc_pkg;

    localparam int OC_NUM_CH = 4;
    localparam int OC_CNT_W  = 16;

    typedef enum logic [1:0] {
        ACT_OFF  = 2'b00,
        ACT_TOG  = 2'b01,
        ACT_LOW  = 2'b10,
        ACT_HIGH = 2'b11
    } oc_act_e;

    function automatic logic oc_apply(input oc_act_e act, input logic cur);
        logic nxt;
        case (act)
            ACT_TOG:  nxt = ~cur;
            ACT_LOW:  nxt = 1'b0;
            ACT_HIGH: nxt = 1'b1;
            default:  nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/oc_ctl_reg.sv
module oc_ctl_reg #(
    parameter int NUM_CH = oc_pkg::OC_NUM_CH,
    localparam int CTL_W = 2 * NUM_CH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [CTL_W-1:0] wdata_i,
    output logic [CTL_W-1:0] codes_o
);

    typedef struct packed {
        logic [CTL_W-1:0] ctl;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            st_d.ctl = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Lowest channel sits in the top bit pair; re-pack so codes_o[2k+:2] is channel k.
    for (genvar k = 0; k < NUM_CH; k++) begin : g_unpack
        assign codes_o[2*k +: 2] = st_q.ctl[CTL_W-1-2*k -: 2];
    end

    // R8: a write becomes visible only after the edge
    a_r8_ctl_write_lands : assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (st_q.ctl == $past(wdata_i)));

endmodule

// File: rtl/oc_channel.sv
module oc_channel
    import oc_pkg::*;
#(
    parameter int CNT_W = oc_pkg::OC_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_i,
    input  logic             count_stb_i,
    input  logic             en_i,
    input  logic [1:0]       code_i,
    input  logic             cmp_we_i,
    input  logic [CNT_W-1:0] cmp_wdata_i,
    output logic             pin_o,
    output logic             oe_o,
    output logic             match_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cmp;
        logic             pin;
        logic             match;
    } ch_state_t;

    ch_state_t st_d, st_q;
    oc_act_e   act;
    logic      hit;

    assign act = oc_act_e'(code_i);

    always_comb begin
        st_d       = st_q;
        hit        = en_i && count_stb_i && (count_i == st_q.cmp);
        st_d.match = hit;
        if (hit) begin
            st_d.pin = oc_apply(act, st_q.pin);
        end
        if (cmp_we_i) begin
            st_d.cmp = cmp_wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_o   = st_q.pin;
    assign match_o = st_q.match;
    assign oe_o    = en_i && (act != ACT_OFF);

    // R3: toggle inverts the latch
    a_r3_toggle : assert property (@(posedge clk) disable iff (!rst_n)
        (hit && act == ACT_TOG) |=> (pin_o != $past(pin_o)));

    // R4: drive low / drive high
    a_r4_drive_low : assert property (@(posedge clk) disable iff (!rst_n)
        (hit && act == ACT_LOW) |=> !pin_o);
    a_r4_drive_high : assert property (@(posedge clk) disable iff (!rst_n)
        (hit && act == ACT_HIGH) |=> pin_o);

    // R5: disconnected code holds the latch but still flags
    a_r5_off_holds : assert property (@(posedge clk) disable iff (!rst_n)
        (hit && act == ACT_OFF) |=> ($stable(pin_o) && match_o));

    // R9: no strobe, no match, no pin change
    a_r9_no_strobe : assert property (@(posedge clk) disable iff (!rst_n)
        !count_stb_i |=> (!match_o && $stable(pin_o)));

    // R7: a disabled channel stays still
    a_r7_disabled_still : assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!match_o && $stable(pin_o)));

    // R6: the flag lasts one cycle per strobed count
    a_r6_flag_needs_stb : assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> $past(count_stb_i));

endmodule

// File: rtl/oc_action_unit.sv
module oc_action_unit
    import oc_pkg::*;
#(
    parameter int NUM_CH   = oc_pkg::OC_NUM_CH,
    parameter int CNT_W    = oc_pkg::OC_CNT_W,
    parameter int GATED_CH = NUM_CH - 1,
    localparam int CTL_W   = 2 * NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              count_stb_i,
    input  logic              sel_i,
    input  logic              ctl_we_i,
    input  logic [CTL_W-1:0]  ctl_wdata_i,
    input  logic [NUM_CH-1:0] cmp_we_i,
    input  logic [CNT_W-1:0]  cmp_wdata_i,
    output logic [NUM_CH-1:0] pin_o,
    output logic [NUM_CH-1:0] oe_o,
    output logic [NUM_CH-1:0] match_o
);

    logic [CTL_W-1:0]  codes;
    logic [NUM_CH-1:0] ch_en;

    oc_ctl_reg #(
        .NUM_CH (NUM_CH)
    ) ctl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (ctl_we_i),
        .wdata_i (ctl_wdata_i),
        .codes_o (codes)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        if (k == GATED_CH) begin : g_gated
            assign ch_en[k] = ~sel_i;
        end else begin : g_free
            assign ch_en[k] = 1'b1;
        end

        oc_channel #(
            .CNT_W (CNT_W)
        ) ch_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .count_i     (count_i),
            .count_stb_i (count_stb_i),
            .en_i        (ch_en[k]),
            .code_i      (codes[2*k +: 2]),
            .cmp_we_i    (cmp_we_i[k]),
            .cmp_wdata_i (cmp_wdata_i),
            .pin_o       (pin_o[k]),
            .oe_o        (oe_o[k]),
            .match_o     (match_o[k])
        );
    end

    // R7: shared pin released while select is high
    a_r7_gated_oe_off : assert property (@(posedge clk) disable iff (!rst_n)
        sel_i |-> !oe_o[GATED_CH]);

    // R1: every indicator low in the first cycle after reset
    a_r1_reset_quiet : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_o == '0 && oe_o == '0 && match_o == '0));

endmodule

// File: tb/oc_action_unit_tb_top.sv
module oc_action_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] count_i = '0;
    logic        count_stb_i = 1'b0;
    logic        sel_i = 1'b0;
    logic        ctl_we_i = 1'b0;
    logic [7:0]  ctl_wdata_i = '0;
    logic [3:0]  cmp_we_i = '0;
    logic [15:0] cmp_wdata_i = '0;
    logic [3:0]  pin_o, oe_o, match_o;

    always #2.5 clk = ~clk;

    oc_action_unit dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .count_i     (count_i),
        .count_stb_i (count_stb_i),
        .sel_i       (sel_i),
        .ctl_we_i    (ctl_we_i),
        .ctl_wdata_i (ctl_wdata_i),
        .cmp_we_i    (cmp_we_i),
        .cmp_wdata_i (cmp_wdata_i),
        .pin_o       (pin_o),
        .oe_o        (oe_o),
        .match_o     (match_o)
    );

    int          n_checks = 0;
    int          n_err = 0;
    bit          done = 1'b0;
    logic [15:0] cmp_m [4];
    logic [7:0]  ctl_m = '0;
    logic [3:0]  pin_m = '0;
    logic [3:0]  match_m = '0;

    function automatic logic [1:0] code_of(input logic [7:0] c, input int k);
        return c[7-2*k -: 2];
    endfunction

    function automatic logic next_pin(input logic [1:0] code, input logic cur);
        case (code)
            2'b01:   return ~cur;
            2'b10:   return 1'b0;
            2'b11:   return 1'b1;
            default: return cur;
        endcase
    endfunction

    function automatic logic [3:0] oe_exp(input logic [7:0] c, input logic sel);
        logic [3:0] r;
        for (int k = 0; k < 4; k++) begin
            r[k] = (code_of(c, k) != 2'b00) && ((k != 3) || !sel);
        end
        return r;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "pin_o", {12'h0, pin_o}, {12'h0, pin_m});
        chk(tag, "oe_o", {12'h0, oe_o}, {12'h0, oe_exp(ctl_m, sel_i)});
        chk(tag, "match_o", {12'h0, match_o}, {12'h0, match_m});
    endtask

    // Drive one cycle, update the model at the edge, check at the falling edge.
    task automatic step(input logic stb, input logic [15:0] cnt, input logic sel,
                        input logic cwe, input logic [7:0] cdat,
                        input logic [3:0] mwe, input logic [15:0] mdat,
                        input string tag);
        count_stb_i = stb; count_i = cnt; sel_i = sel;
        ctl_we_i = cwe; ctl_wdata_i = cdat; cmp_we_i = mwe; cmp_wdata_i = mdat;
        @(posedge clk);
        for (int k = 0; k < 4; k++) begin
            logic hit;
            hit = stb && (cnt == cmp_m[k]) && ((k != 3) || !sel);
            match_m[k] = hit;
            if (hit) pin_m[k] = next_pin(code_of(ctl_m, k), pin_m[k]);
        end
        if (cwe) ctl_m = cdat;
        for (int k = 0; k < 4; k++) if (mwe[k]) cmp_m[k] = mdat;
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_err++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0C5EED01));
        for (int k = 0; k < 4; k++) cmp_m[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R2: ch2 toggle, ch3 low, ch4 high, ch5 off
        step(0, 16'h0, 0, 1, 8'b01_10_11_00, 4'h0, 16'h0, "R2");
        chk("R2", "oe layout", {12'h0, oe_o}, 16'h0007);
        step(0, 16'h0, 0, 0, 8'h00, 4'hF, 16'h1234, "R2");
        // R3 R4 R5: one strobed match on all channels
        step(1, 16'h1234, 0, 0, 8'h00, 4'h0, 16'h0, "R3");
        chk("R3", "toggle ch2", {15'h0, pin_o[0]}, 16'h1);
        chk("R4", "low ch3 high ch4", {14'h0, pin_o[2:1]}, 16'h2);
        chk("R5", "off ch5 hold+flag", {14'h0, pin_o[3], match_o[3]}, 16'h1);
        // R9: equal count without strobe
        step(0, 16'h1234, 0, 0, 8'h00, 4'h0, 16'h0, "R9");
        chk("R9", "no match", {12'h0, match_o}, 16'h0);
        // R6: strobed unequal count
        step(1, 16'h1235, 0, 0, 8'h00, 4'h0, 16'h0, "R6");
        chk("R6", "no match unequal", {12'h0, match_o}, 16'h0);
        step(1, 16'h1234, 0, 0, 8'h00, 4'h0, 16'h0, "R6");
        chk("R6", "toggle back", {15'h0, pin_o[0]}, 16'h0);
        // R7: ch5 to high, select on
        step(0, 16'h0, 1, 1, 8'b01_10_11_11, 4'h0, 16'h0, "R7");
        chk("R7", "oe ch5 off", {15'h0, oe_o[3]}, 16'h0);
        step(1, 16'h1234, 1, 0, 8'h00, 4'h0, 16'h0, "R7");
        chk("R7", "ch5 still", {14'h0, pin_o[3], match_o[3]}, 16'h0);
        step(1, 16'h1234, 0, 0, 8'h00, 4'h0, 16'h0, "R7");
        chk("R7", "ch5 active again", {14'h0, pin_o[3], match_o[3]}, 16'h3);
        // R8: same-edge compare write
        step(1, 16'h0042, 0, 0, 8'h00, 4'h1, 16'h0042, "R8");
        chk("R8", "old cmp used", {15'h0, match_o[0]}, 16'h0);
        step(1, 16'h0042, 0, 0, 8'h00, 4'h0, 16'h0, "R8");
        chk("R8", "new cmp used", {15'h0, match_o[0]}, 16'h1);

        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] cnt;
            logic [3:0]  mwe;
            cnt = ($urandom % 2) ? cmp_m[$urandom % 4] : 16'($urandom % 8);
            mwe = ($urandom % 8 == 0) ? 4'($urandom) : 4'h0;
            step(($urandom % 4) != 0, cnt, ($urandom % 4) == 0,
                 ($urandom % 10) == 0, 8'($urandom), mwe, 16'($urandom % 8), "R6");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule